// File: doc/BRIEF.md
# TLB Entry Commit Path

This block is the write side of a small translation buffer. Software loads two 64-bit page-attribute staging registers (one for the even page and one for the odd page of a pair) and a frame-mask register. It then issues a commit strobe with an index. On that strobe the block copies a masked page frame number, a 2-bit uncached attribute for each half, and one merged global bit into the indexed slot of an eight-entry data array. A second read port lets the address phase of the system bus look up the uncached attribute of a page. The block presents that attribute for the bus bits that carry it, but only for the request kinds that use it.

Staging loads obey the processor's access mode. In full (64-bit) mode the whole word is written. In narrow mode only the low 32 bits are taken and sign-extended upward, and the two attribute bits at the top of the word are left alone. As a result, bits 33..31 of a narrowly loaded register are always all zeros or all ones. All staging registers can be read back through a select port.

Top module: `tlbw_commit_top`

## Requirements
- R1: After reset, every staging register reads back as zero and every field of every array entry is zero.
- R2: With `full_mode` high, a register load stores all 64 bits of `reg_wr_data`, visible on `reg_rd_data` from the next cycle. Select 0 is the even staging register, 1 is the odd staging register and 2 is the frame mask. Select 3 reads as zero, and a load to it changes nothing.
- R3: With `full_mode` low, a load to a staging register sets bits 31..0 to `reg_wr_data[31:0]` and bits 61..32 to copies of `reg_wr_data[31]`.
- R4: With `full_mode` low, a load leaves bits 63..62 (the uncached attribute) of the target staging register unchanged.
- R5: After a narrow-mode load, bits 33..31 of the target staging register are all equal.
- R6: The frame mask occupies bits 33..6 of its register, and all its other bits read as zero. Narrow-mode loads sign-extend the mask in the same way as in R3.
- R7: A commit stores, for each half, staging bits 33..6 with every bit that is set in the frame mask forced to zero. The stored entry is visible on the read port from the cycle after the strobe.
- R8: A commit stores bits 63..62 of each staging register as that half's uncached attribute.
- R9: The stored global bit is the AND of bit 0 of the even and odd staging registers.
- R10: When `req_valid` is high and `req_kind` is 1..7, `attr_valid` is 1 and `attr_uc` is the stored attribute of entry `req_idx`, taken from the odd half when `req_odd` is 1, all in the same cycle. The kinds are: 1 double-word read, 2 word read, 3 partial read, 4 double-word write, 5 word write, 6 partial write, 7 accelerated block write, all uncached. For kind 0 (cached block read), or when `req_valid` is low, both outputs are zero.
- R11: A commit and a staging load in the same cycle commit the values held before that load.
- R12: A commit changes no entry other than the one at `tlb_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_mode | input | 1 | 1 = 64-bit loads allowed, 0 = narrow mode |
| reg_wr_en | input | 1 | Staging register load strobe |
| reg_wr_sel | input | 2 | Register selected for the load |
| reg_wr_data | input | 64 | Load data |
| reg_rd_sel | input | 2 | Register selected for readback |
| reg_rd_data | output | 64 | Readback value |
| tlb_wr | input | 1 | Commit strobe |
| tlb_idx | input | 3 | Entry written by the commit |
| rd_idx | input | 3 | Entry shown on the read port |
| rd_pfn_even | output | 28 | Stored frame number, even half |
| rd_pfn_odd | output | 28 | Stored frame number, odd half |
| rd_uc_even | output | 2 | Stored uncached attribute, even half |
| rd_uc_odd | output | 2 | Stored uncached attribute, odd half |
| rd_global | output | 1 | Stored global bit |
| req_valid | input | 1 | Bus address cycle in progress |
| req_kind | input | 3 | Kind of bus request |
| req_idx | input | 3 | Entry translating the request |
| req_odd | input | 1 | Request targets the odd page |
| attr_valid | output | 1 | Attribute is being driven |
| attr_uc | output | 2 | Attribute for bus bits 59..58 |

## Verification
A staging load or commit takes effect at the first rising edge after its strobe. Readback and the read port are combinational, so the bench drives each strobe on a falling edge, lets one rising edge pass, and samples at the next falling edge. The bus attribute has no register in its path and is checked 1 ns after its request inputs change, with no edge in between. The same-cycle case of R11 is checked by driving a load and a commit on the same falling edge.

// File: rtl/tlbw_pkg.sv
`timescale 1ns/1ps
package tlbw_pkg;
    localparam int WORD_W   = 64;
    localparam int NARROW_W = 32;
    localparam int PFN_LO   = 6;
    localparam int UC_LO    = 62;
    localparam int UC_W     = 2;

    typedef enum logic [2:0] {
        RK_CACHED_BLK_RD = 3'd0,
        RK_UC_RD_DW      = 3'd1,
        RK_UC_RD_W       = 3'd2,
        RK_UC_RD_PART    = 3'd3,
        RK_UC_WR_DW      = 3'd4,
        RK_UC_WR_W       = 3'd5,
        RK_UC_WR_PART    = 3'd6,
        RK_UC_ACC_BLK_WR = 3'd7
    } req_kind_e;

    typedef enum logic {
        LD_NARROW = 1'b0,
        LD_FULL   = 1'b1
    } load_pol_e;

    typedef enum logic [1:0] {
        SEL_LO_EVEN = 2'd0,
        SEL_LO_ODD  = 2'd1,
        SEL_FMASK   = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    function automatic logic [WORD_W-1:0] shape_load(
        input load_pol_e         pol,
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v
    );
        logic [WORD_W-1:0] r;
        unique case (pol)
            LD_FULL:   r = new_v;
            LD_NARROW: r = {old_v[WORD_W-1:UC_LO],
                            {(UC_LO-NARROW_W){new_v[NARROW_W-1]}},
                            new_v[NARROW_W-1:0]};
            default:   r = new_v;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tlbw_lo_regs.sv
`timescale 1ns/1ps
module tlbw_lo_regs #(
    parameter int PFN_W = 28
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        full_mode,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [tlbw_pkg::WORD_W-1:0] wr_data,
    output logic [tlbw_pkg::WORD_W-1:0] lo_even,
    output logic [tlbw_pkg::WORD_W-1:0] lo_odd,
    output logic [PFN_W-1:0]            fmask
);
    import tlbw_pkg::*;

    load_pol_e         pol;
    reg_sel_e          sel;
    logic [PFN_W-1:0]  fmask_next;

    assign pol = full_mode ? LD_FULL : LD_NARROW;
    assign sel = reg_sel_e'(wr_sel);

    // Mask field sits at the frame-number position; narrow loads sign-extend it.
    always_comb begin
        for (int k = 0; k < PFN_W; k++) begin
            if (pol == LD_FULL || (PFN_LO + k) < NARROW_W)
                fmask_next[k] = wr_data[PFN_LO + k];
            else
                fmask_next[k] = wr_data[NARROW_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_even <= '0;
            lo_odd  <= '0;
            fmask   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_LO_EVEN: lo_even <= shape_load(pol, lo_even, wr_data);
                SEL_LO_ODD:  lo_odd  <= shape_load(pol, lo_odd, wr_data);
                SEL_FMASK:   fmask   <= fmask_next;
                default:     ;
            endcase
        end
    end

    // R5: a narrow load leaves bits 33..31 uniform
    a_r5_even_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_mode && wr_sel == 2'd0)
        |=> ((&lo_even[33:31]) || !(|lo_even[33:31])));

    // R4: a narrow load keeps the uncached attribute
    a_r4_odd_uc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_mode && wr_sel == 2'd1)
        |=> (lo_odd[WORD_W-1:UC_LO] == $past(lo_odd[WORD_W-1:UC_LO])));

    // R2: select 3 touches no register
    a_r2_none_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3)
        |=> ($stable(lo_even) && $stable(lo_odd) && $stable(fmask)));
endmodule

// File: rtl/tlbw_entry_array.sv
`timescale 1ns/1ps
module tlbw_entry_array #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 28,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PFN_W-1:0] wr_pfn_even,
    input  logic [PFN_W-1:0] wr_pfn_odd,
    input  logic [1:0]       wr_uc_even,
    input  logic [1:0]       wr_uc_odd,
    input  logic             wr_global,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PFN_W-1:0] rd_pfn_even,
    output logic [PFN_W-1:0] rd_pfn_odd,
    output logic [1:0]       rd_uc_even,
    output logic [1:0]       rd_uc_odd,
    output logic             rd_global,
    input  logic [IDX_W-1:0] bus_idx,
    output logic [1:0]       bus_uc_even,
    output logic [1:0]       bus_uc_odd
);
    logic [PFN_W-1:0] pfn_e [ENTRIES];
    logic [PFN_W-1:0] pfn_o [ENTRIES];
    logic [1:0]       uc_e  [ENTRIES];
    logic [1:0]       uc_o  [ENTRIES];
    logic             glb   [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pfn_e[i] <= '0;
                pfn_o[i] <= '0;
                uc_e[i]  <= '0;
                uc_o[i]  <= '0;
                glb[i]   <= 1'b0;
            end else if (hit) begin
                pfn_e[i] <= wr_pfn_even;
                pfn_o[i] <= wr_pfn_odd;
                uc_e[i]  <= wr_uc_even;
                uc_o[i]  <= wr_uc_odd;
                glb[i]   <= wr_global;
            end
        end

        // R12: a commit elsewhere leaves this slot alone
        a_r12_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx != IDX_W'(i))
            |=> ($stable(pfn_e[i]) && $stable(pfn_o[i]) && $stable(uc_e[i])
                 && $stable(uc_o[i]) && $stable(glb[i])));
    end

    assign rd_pfn_even = pfn_e[rd_idx];
    assign rd_pfn_odd  = pfn_o[rd_idx];
    assign rd_uc_even  = uc_e[rd_idx];
    assign rd_uc_odd   = uc_o[rd_idx];
    assign rd_global   = glb[rd_idx];
    assign bus_uc_even = uc_e[bus_idx];
    assign bus_uc_odd  = uc_o[bus_idx];
endmodule

// File: rtl/tlbw_bus_attr.sv
`timescale 1ns/1ps
module tlbw_bus_attr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       req_odd,
    input  logic [1:0] uc_even,
    input  logic [1:0] uc_odd,
    output logic       attr_valid,
    output logic [1:0] attr_uc
);
    import tlbw_pkg::*;

    req_kind_e kind;
    logic      drive;

    assign kind = req_kind_e'(req_kind);

    always_comb begin
        unique case (kind)
            RK_UC_RD_DW, RK_UC_RD_W, RK_UC_RD_PART,
            RK_UC_WR_DW, RK_UC_WR_W, RK_UC_WR_PART,
            RK_UC_ACC_BLK_WR: drive = req_valid;
            RK_CACHED_BLK_RD: drive = 1'b0;
            default:          drive = 1'b0;
        endcase
    end

    always_comb begin
        attr_valid = drive;
        attr_uc    = drive ? (req_odd ? uc_odd : uc_even) : 2'b00;
    end

    // R10: nothing is driven outside a qualifying address cycle
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind == 3'd0) |-> (!attr_valid && attr_uc == 2'b00));
endmodule

// File: rtl/tlbw_commit_top.sv
`timescale 1ns/1ps
module tlbw_commit_top #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 28,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_mode,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_wr_sel,
    input  logic [63:0]      reg_wr_data,
    input  logic [1:0]       reg_rd_sel,
    output logic [63:0]      reg_rd_data,
    input  logic             tlb_wr,
    input  logic [IDX_W-1:0] tlb_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PFN_W-1:0] rd_pfn_even,
    output logic [PFN_W-1:0] rd_pfn_odd,
    output logic [1:0]       rd_uc_even,
    output logic [1:0]       rd_uc_odd,
    output logic             rd_global,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             req_odd,
    output logic             attr_valid,
    output logic [1:0]       attr_uc
);
    import tlbw_pkg::*;

    localparam int PFN_HI = PFN_LO + PFN_W - 1;

    logic [WORD_W-1:0] lo_even, lo_odd;
    logic [PFN_W-1:0]  fmask;
    logic [PFN_W-1:0]  c_pfn_even, c_pfn_odd;
    logic              c_global;
    logic [1:0]        b_uc_even, b_uc_odd;
    reg_sel_e          rsel;

    tlbw_lo_regs #(.PFN_W(PFN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .full_mode(full_mode),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
        .lo_even(lo_even), .lo_odd(lo_odd), .fmask(fmask)
    );

    // Commit data: masked frame numbers and merged global bit.
    assign c_pfn_even = lo_even[PFN_HI:PFN_LO] & ~fmask;
    assign c_pfn_odd  = lo_odd[PFN_HI:PFN_LO]  & ~fmask;
    assign c_global   = lo_even[0] & lo_odd[0];

    tlbw_entry_array #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tlb_wr), .wr_idx(tlb_idx),
        .wr_pfn_even(c_pfn_even), .wr_pfn_odd(c_pfn_odd),
        .wr_uc_even(lo_even[WORD_W-1:UC_LO]), .wr_uc_odd(lo_odd[WORD_W-1:UC_LO]),
        .wr_global(c_global),
        .rd_idx(rd_idx),
        .rd_pfn_even(rd_pfn_even), .rd_pfn_odd(rd_pfn_odd),
        .rd_uc_even(rd_uc_even), .rd_uc_odd(rd_uc_odd), .rd_global(rd_global),
        .bus_idx(req_idx), .bus_uc_even(b_uc_even), .bus_uc_odd(b_uc_odd)
    );

    tlbw_bus_attr u_attr (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_odd(req_odd),
        .uc_even(b_uc_even), .uc_odd(b_uc_odd),
        .attr_valid(attr_valid), .attr_uc(attr_uc)
    );

    assign rsel = reg_sel_e'(reg_rd_sel);

    always_comb begin
        reg_rd_data = '0;
        unique case (rsel)
            SEL_LO_EVEN: reg_rd_data = lo_even;
            SEL_LO_ODD:  reg_rd_data = lo_odd;
            SEL_FMASK:   reg_rd_data[PFN_HI:PFN_LO] = fmask;
            default:     reg_rd_data = '0;
        endcase
    end

    // R7: masked frame bits read back as zero after a commit
    a_r7_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr |=> ((rd_idx != $past(tlb_idx)) ||
                    (((rd_pfn_even | rd_pfn_odd) & $past(fmask)) == '0)));

    // R9: stored global bit is the AND of both bit 0 values
    a_r9_global_and: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr |=> ((rd_idx != $past(tlb_idx)) ||
                    (rd_global == ($past(lo_even[0]) & $past(lo_odd[0])))));

    // R8: stored attributes come from the staging top bits
    a_r8_uc_copy: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr |=> ((rd_idx != $past(tlb_idx)) ||
                    ({rd_uc_even, rd_uc_odd} ==
                     {$past(lo_even[WORD_W-1:UC_LO]), $past(lo_odd[WORD_W-1:UC_LO])})));
endmodule

// File: tb/tlbw_commit_top_test.sv
`timescale 1ns/1ps
module tlbw_commit_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        full_mode;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_sel;
    logic [63:0] reg_wr_data;
    logic [1:0]  reg_rd_sel;
    logic [63:0] reg_rd_data;
    logic        tlb_wr;
    logic [2:0]  tlb_idx, rd_idx, req_idx;
    logic [27:0] rd_pfn_even, rd_pfn_odd;
    logic [1:0]  rd_uc_even, rd_uc_odd, attr_uc;
    logic        rd_global, req_valid, req_odd, attr_valid;
    logic [2:0]  req_kind;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [63:0] m_lo0, m_lo1;
    logic [27:0] m_mask;
    logic [27:0] m_pe [8];
    logic [27:0] m_po [8];
    logic [1:0]  m_ue [8];
    logic [1:0]  m_uo [8];
    logic        m_g  [8];

    always #4 clk = ~clk;

    tlbw_commit_top uut (
        .clk(clk), .rst_n(rst_n), .full_mode(full_mode),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .tlb_wr(tlb_wr), .tlb_idx(tlb_idx), .rd_idx(rd_idx),
        .rd_pfn_even(rd_pfn_even), .rd_pfn_odd(rd_pfn_odd),
        .rd_uc_even(rd_uc_even), .rd_uc_odd(rd_uc_odd), .rd_global(rd_global),
        .req_valid(req_valid), .req_kind(req_kind), .req_idx(req_idx),
        .req_odd(req_odd), .attr_valid(attr_valid), .attr_uc(attr_uc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int k);
        logic [31:0] a, b;
        a = 32'(k) * 32'h9E3779B9 + 32'h1234_5671;
        b = 32'(k + 3) * 32'h7F4A7C15 ^ 32'hA5A5_0F0F;
        return {a, b};
    endfunction

    function automatic logic [63:0] model_load(input logic [63:0] old_v,
                                               input logic [63:0] d, input bit full);
        if (full) return d;
        return {old_v[63:62], {30{d[31]}}, d[31:0]};
    endfunction

    function automatic logic [63:0] mask_word(input logic [27:0] m);
        logic [63:0] w;
        w = '0;
        w[33:6] = m;
        return w;
    endfunction

    task automatic model_reg(input logic [1:0] sel, input logic [63:0] d, input bit full);
        logic [63:0] v;
        case (sel)
            2'd0: m_lo0 = model_load(m_lo0, d, full);
            2'd1: m_lo1 = model_load(m_lo1, d, full);
            2'd2: begin
                v = model_load(64'd0, d, full);
                m_mask = v[33:6];
            end
            default: ;
        endcase
    endtask

    task automatic model_commit(input int i);
        m_pe[i] = m_lo0[33:6] & ~m_mask;
        m_po[i] = m_lo1[33:6] & ~m_mask;
        m_ue[i] = m_lo0[63:62];
        m_uo[i] = m_lo1[63:62];
        m_g[i]  = m_lo0[0] & m_lo1[0];
    endtask

    task automatic check_regs(input string req);
        reg_rd_sel = 2'd0; #1; chk(req, reg_rd_data, m_lo0);
        reg_rd_sel = 2'd1; #1; chk(req, reg_rd_data, m_lo1);
        reg_rd_sel = 2'd2; #1; chk(req, reg_rd_data, mask_word(m_mask));
        reg_rd_sel = 2'd3; #1; chk(req, reg_rd_data, 64'd0);
    endtask

    task automatic check_entry(input int i, input string req);
        rd_idx = 3'(i);
        #1;
        chk(req, {3'd0, rd_pfn_even, rd_pfn_odd, rd_uc_even, rd_uc_odd, rd_global},
                 {3'd0, m_pe[i], m_po[i], m_ue[i], m_uo[i], m_g[i]});
    endtask

    task automatic ldreg(input logic [1:0] sel, input logic [63:0] d, input bit full);
        @(negedge clk);
        full_mode = full; reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_reg(sel, d, full);
    endtask

    task automatic commit(input int i);
        @(negedge clk);
        tlb_wr = 1'b1; tlb_idx = 3'(i);
        @(negedge clk);
        tlb_wr = 1'b0;
        model_commit(i);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; full_mode = 1'b1; reg_wr_en = 1'b0; reg_wr_sel = '0;
        reg_wr_data = '0; reg_rd_sel = '0; tlb_wr = 1'b0; tlb_idx = '0;
        rd_idx = '0; req_valid = 1'b0; req_kind = '0; req_idx = '0; req_odd = 1'b0;
        m_lo0 = '0; m_lo1 = '0; m_mask = '0;
        for (int i = 0; i < 8; i++) begin
            m_pe[i] = '0; m_po[i] = '0; m_ue[i] = '0; m_uo[i] = '0; m_g[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_regs("R1 reset regs");
        for (int i = 0; i < 8; i++) check_entry(i, "R1 reset entry");

        // R9: all four combinations of the two bit-0 values
        for (int c = 0; c < 4; c++) begin
            ldreg(2'd0, pat(c) & ~64'd1 | 64'(c & 1), 1'b1);
            ldreg(2'd1, pat(c + 9) & ~64'd1 | 64'((c >> 1) & 1), 1'b1);
            commit(c);
            check_entry(c, "R9 global merge");
        end

        // R2 R6 R7 R8 R12: full-mode sweep over every entry
        for (int i = 0; i < 8; i++) begin
            ldreg(2'd2, pat(40 + i), 1'b1);
            ldreg(2'd0, pat(2 * i + 1), 1'b1);
            ldreg(2'd1, pat(2 * i + 2), 1'b1);
            check_regs("R2 R6 full load");
            commit(i);
            check_entry(i, "R7 R8 commit");
            for (int j = 0; j < 8; j++) check_entry(j, "R12 others hold");
        end

        // R2: select 3 is ignored
        ldreg(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        check_regs("R2 select 3 ignored");

        // R3 R4 R5 R6: narrow loads, both signs of bit 31
        for (int k = 0; k < 6; k++) begin
            logic [63:0] d;
            d = pat(70 + k);
            d[31] = k[0];
            ldreg(2'(k % 3), d, 1'b0);
            check_regs("R3 R4 R6 narrow load");
            reg_rd_sel = 2'(k % 3 == 2 ? 0 : k % 3);
            #1;
            chk("R5 bits 33..31 uniform",
                64'((&reg_rd_data[33:31]) || !(|reg_rd_data[33:31])), 64'd1);
        end
        commit(5);
        check_entry(5, "R3 R4 narrow commit");

        // R11: load and commit in the same cycle commit the old values
        ldreg(2'd0, pat(90), 1'b1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = pat(91); full_mode = 1'b1;
        tlb_wr = 1'b1; tlb_idx = 3'd6;
        @(negedge clk);
        reg_wr_en = 1'b0; tlb_wr = 1'b0;
        model_commit(6);
        model_reg(2'd0, pat(91), 1'b1);
        check_entry(6, "R11 same-cycle commit");
        check_regs("R11 load after commit");

        // R10: bus attribute sweep over kinds, entries, halves, valid
        for (int v = 0; v < 2; v++)
            for (int kd = 0; kd < 8; kd++)
                for (int i = 0; i < 8; i++)
                    for (int o = 0; o < 2; o++) begin
                        logic       ev;
                        logic [1:0] eu;
                        req_valid = v[0]; req_kind = 3'(kd); req_idx = 3'(i); req_odd = o[0];
                        #1;
                        ev = (v == 1) && (kd != 0);
                        eu = ev ? (o == 1 ? m_uo[i] : m_ue[i]) : 2'b00;
                        chk("R10 bus attribute", {61'd0, attr_valid, attr_uc}, {61'd0, ev, eu});
                    end
        req_valid = 1'b0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule